// File: doc/BRIEF.md
# Serial Control Port with Channel Peak Readback

This block is the register-access slave of a stereo converter. A host talks to it over a four-wire serial link: a serial clock, an active-low select, a data input and a data output. Every transaction is a 16-bit command word, sent most significant bit first. Each word carries a register address in its top four bits and a read flag just below them. The next bit is reserved and ignored. The low ten bits carry the data. Three 10-bit control registers can be written this way, and their contents drive the rest of the converter through a flat output bus.

Two further addresses are read-only peak monitors, one for each audio channel. Each monitor watches a stream of signed 24-bit samples. It keeps the largest magnitude of the sample's upper six bits seen since it was last read. Reading a monitor returns the held value and clears it to zero. A read command does not answer in its own frame: the reply is shifted out during the next frame the host opens. All serial inputs are resynchronised to the block's system clock and sampled there. Serial edges must therefore be several system clocks apart.

Top module: `cvt_ctl_port`

## Requirements
- R1: Serial data is shifted in most significant bit first. A bit is taken on each rising serial clock edge while the select is low. Bits 15..12 of the frame are the address, bit 11 is the read flag (1 = read), bit 10 is ignored, and bits 9..0 are the data.
- R2: A write frame (bit 11 = 0) to address 0, 1 or 2 replaces that control register with bits 9..0. Register k appears on `ctrl_o[10k+9:10k]`.
- R3: A frame is acted on only when the select rises after exactly 16 rising serial clock edges. A frame of 15 or 17 clocks changes no register.
- R4: A read reply goes out during the frame that follows the read command. Bit 15 is driven first, once the select is low. Each later bit follows a falling serial clock edge. The reply holds the read address in bits 15..12, zero in bits 11..10, and the register value right-aligned in bits 9..0. A frame that follows a non-read frame shifts out all zeros.
- R5: Write frames to addresses 3 through 15 leave every control register and both peak values unchanged.
- R6: A read of an unmapped address (5 through 15) returns zero in bits 9..0.
- R7: Tracking is on while bit 0 of control register 2 is 1. Then each valid sample updates the channel's peak to the larger of the held peak and the magnitude of the sample's bits 23..18, read as a signed number; an upper part of -32 gives 32. Address 3 reads the left channel (`smp_i[23:0]`) and address 4 the right channel (`smp_i[47:24]`), zero-extended into bits 9..0.
- R8: Reading a peak register clears that channel's peak to zero. Tracking then resumes from the next sample.
- R9: While bit 0 of control register 2 is 0, samples leave both peaks unchanged.
- R10: After reset all control registers and peaks are zero and `sdo_o` is low.
- R11: Serial clock and data activity while the select is high has no effect on the registers or on a pending reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial command data, MSB first |
| sdo_o | output | 1 | Serial reply data, MSB first |
| smp_vld_i | input | 1 | Sample strobe for both channels |
| smp_i | input | 48 | Signed samples, left in bits 23..0, right in bits 47..24 |
| ctrl_o | output | 30 | Control registers 0..2, ten bits each |

## Verification
The checker takes for granted that the host holds the select low for a whole frame and spaces serial edges far enough apart for the synchroniser to see each one. It also assumes the data input is settled before the rising clock edge it belongs to. The bench drives every serial level for eight system clocks and changes the data only together with a falling serial clock. It changes the select only while the serial clock is low. Samples are applied only between frames, so a clearing read never coincides with a sample strobe.

// File: rtl/cvt_ctl_pkg.sv
package cvt_ctl_pkg;
    // frame geometry
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 10;
    localparam int FRAME_W = ADDR_W + 2 + DATA_W;
    // register population
    localparam int N_CTRL  = 3;
    localparam int N_CH    = 2;
    localparam int PK_BASE = 3;
    // sample path
    localparam int SMP_W   = 24;
    localparam int PK_W    = 6;
    // enable bit location for peak tracking
    localparam int PK_EN_REG = 2;
    localparam int PK_EN_BIT = 0;
endpackage

// File: rtl/cvt_ctl_sync.sv
module cvt_ctl_sync #(
    parameter int          W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST, s2: RST};
        else        st_q <= st_d;
    end

    assign dout_o = st_q.s2;
endmodule

// File: rtl/cvt_ctl_shift.sv
module cvt_ctl_shift #(
    parameter int FRAME_W = 16,
    parameter int RSV_BIT = 10,
    localparam int CNT_W  = $clog2(FRAME_W + 2),
    localparam int CMD_W  = FRAME_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_i,
    input  logic               cs_n_i,
    input  logic               sdi_i,
    input  logic               rsp_vld_i,
    input  logic [FRAME_W-1:0] rsp_word_i,
    output logic               open_o,
    output logic               done_o,
    output logic [CMD_W-1:0]   cmd_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               sdo_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sck_p;
        logic               cs_p;
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic [CMD_W-1:0]   cmd;
    } st_t;

    st_t  st_d, st_q;
    logic sck_rise, sck_fall, cs_fall, cs_rise;

    always_comb begin
        sck_rise = sck_i & ~st_q.sck_p;
        sck_fall = ~sck_i & st_q.sck_p;
        cs_fall  = ~cs_n_i & st_q.cs_p;
        cs_rise  = cs_n_i & ~st_q.cs_p;

        st_d       = st_q;
        st_d.sck_p = sck_i;
        st_d.cs_p  = cs_n_i;
        st_d.done  = 1'b0;

        if (cs_fall) begin
            st_d.cnt = '0;
            st_d.tx  = rsp_vld_i ? rsp_word_i : '0;
        end else if (!cs_n_i) begin
            if (sck_rise) begin
                st_d.rx = {st_q.rx[FRAME_W-2:0], sdi_i};
                if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sck_fall) st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
        end

        if (cs_rise) begin
            st_d.tx = '0;
            if (st_q.cnt == CNT_FULL) begin
                st_d.done = 1'b1;
                st_d.cmd  = {st_q.rx[FRAME_W-1:RSV_BIT+1], st_q.rx[RSV_BIT-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cs_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = cs_fall;
    assign done_o = st_q.done;
    assign cmd_o  = st_q.cmd;
    assign cnt_o  = st_q.cnt;
    assign sdo_o  = st_q.tx[FRAME_W-1];
endmodule

// File: rtl/cvt_ctl_peak.sv
module cvt_ctl_peak #(
    parameter int SMP_W = 24,
    parameter int PK_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             clr_i,
    output logic [PK_W-1:0]  pk_o
);
    typedef struct packed {
        logic [PK_W-1:0] pk;
    } st_t;

    st_t             st_d, st_q;
    logic [PK_W-1:0] head;
    logic [PK_W-1:0] mag;

    always_comb begin
        head = PK_W'(smp_i >> (SMP_W - PK_W));
        mag  = head[PK_W-1] ? (~head + 1'b1) : head;

        st_d = st_q;
        if (clr_i) begin
            st_d.pk = '0;
        end else if (en_i && vld_i && (mag > st_q.pk)) begin
            st_d.pk = mag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pk_o = st_q.pk;
endmodule

// File: rtl/cvt_ctl_port.sv
module cvt_ctl_port
    import cvt_ctl_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_N_CTRL = N_CTRL,
    parameter int P_N_CH   = N_CH,
    parameter int P_SMP_W  = SMP_W,
    parameter int P_PK_W   = PK_W,
    localparam int FW      = P_ADDR_W + 2 + P_DATA_W,
    localparam int CW      = FW - 1,
    localparam int CNTW    = $clog2(FW + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sclk_i,
    input  logic                         cs_n_i,
    input  logic                         sdi_i,
    output logic                         sdo_o,
    input  logic                         smp_vld_i,
    input  logic [P_N_CH*P_SMP_W-1:0]    smp_i,
    output logic [P_N_CTRL*P_DATA_W-1:0] ctrl_o
);
    typedef struct packed {
        logic [P_N_CTRL-1:0][P_DATA_W-1:0] ctrl;
        logic [FW-1:0]                     rsp;
        logic                              rsp_vld;
    } st_t;

    st_t st_d, st_q;

    // synchronised serial pins: {sdi, cs_n, sclk}
    logic [2:0] pin_s;

    cvt_ctl_sync #(.W(3), .RST(3'b010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({sdi_i, cs_n_i, sclk_i}),
        .dout_o (pin_s)
    );

    logic            open_p;
    logic            done_p;
    logic [CW-1:0]   cmd;
    logic [CNTW-1:0] bit_cnt;
    logic            sdo_w;

    cvt_ctl_shift #(.FRAME_W(FW), .RSV_BIT(P_DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (pin_s[0]),
        .cs_n_i     (pin_s[1]),
        .sdi_i      (pin_s[2]),
        .rsp_vld_i  (st_q.rsp_vld),
        .rsp_word_i (st_q.rsp),
        .open_o     (open_p),
        .done_o     (done_p),
        .cmd_o      (cmd),
        .cnt_o      (bit_cnt),
        .sdo_o      (sdo_w)
    );

    // command fields after the reserved bit has been dropped
    logic [P_ADDR_W-1:0] c_addr;
    logic                c_rd;
    logic [P_DATA_W-1:0] c_data;

    assign c_addr = cmd[CW-1 -: P_ADDR_W];
    assign c_rd   = cmd[P_DATA_W];
    assign c_data = cmd[P_DATA_W-1:0];

    // peak trackers, one per channel
    logic [P_N_CH*P_PK_W-1:0] pk_all;
    logic [P_N_CH-1:0]        pk_clr;
    logic                     pk_en;

    assign pk_en = st_q.ctrl[PK_EN_REG][PK_EN_BIT];

    for (genvar c = 0; c < P_N_CH; c++) begin : g_pk
        assign pk_clr[c] = done_p && c_rd && (c_addr == P_ADDR_W'(PK_BASE + c));

        cvt_ctl_peak #(.SMP_W(P_SMP_W), .PK_W(P_PK_W)) u_pk (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (pk_en),
            .vld_i (smp_vld_i),
            .smp_i (smp_i[c*P_SMP_W +: P_SMP_W]),
            .clr_i (pk_clr[c]),
            .pk_o  (pk_all[c*P_PK_W +: P_PK_W])
        );
    end

    logic [P_DATA_W-1:0] rdata;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < P_N_CTRL; i++) begin
            if (c_addr == P_ADDR_W'(i)) rdata = st_q.ctrl[i];
        end
        for (int c = 0; c < P_N_CH; c++) begin
            if (c_addr == P_ADDR_W'(PK_BASE + c)) begin
                rdata = {{(P_DATA_W-P_PK_W){1'b0}}, pk_all[c*P_PK_W +: P_PK_W]};
            end
        end

        st_d = st_q;
        if (open_p) st_d.rsp_vld = 1'b0;

        if (done_p) begin
            if (c_rd) begin
                st_d.rsp     = {c_addr, 2'b00, rdata};
                st_d.rsp_vld = 1'b1;
            end else begin
                for (int i = 0; i < P_N_CTRL; i++) begin
                    if (c_addr == P_ADDR_W'(i)) st_d.ctrl[i] = c_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o  = sdo_w;
    assign ctrl_o = st_q.ctrl;
endmodule

// File: rtl/cvt_ctl_port_chk.sv
module cvt_ctl_port_chk #(
    parameter int ADDR_W  = 4,
    parameter int CTRL_W  = 30,
    parameter int N_CH    = 2,
    parameter int PK_W    = 6,
    parameter int N_CTRL  = 3,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 done,
    input logic                 rd,
    input logic [ADDR_W-1:0]    addr,
    input logic [CTRL_W-1:0]    ctrl,
    input logic [N_CH*PK_W-1:0] pk,
    input logic [N_CH-1:0]      clr,
    input logic [CNT_W-1:0]     cnt,
    input logic                 cs_lvl,
    input logic                 sdo
);
    // R2: control registers move only in the cycle after a committed frame
    a_r2_ctrl_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(done));

    // R5: writes to read-only or unmapped addresses leave the registers alone
    a_r5_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd && (addr >= ADDR_W'(N_CTRL))) |=> $stable(ctrl));

    // R3: bit counter saturates one past a full frame
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_W + 1));

    // R11: output stays low while the select has been high
    a_r11_idle_sdo_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !sdo);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        // R7: magnitude of a 6-bit signed value never exceeds 32
        a_r7_peak_bound: assert property (@(posedge clk) disable iff (!rst_n)
            pk[c*PK_W +: PK_W] <= PK_W'(1 << (PK_W - 1)));

        // R8: a peak only falls after a clearing read
        a_r8_peak_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (pk[c*PK_W +: PK_W] < $past(pk[c*PK_W +: PK_W])) |-> $past(clr[c]));
    end
endmodule

bind cvt_ctl_port cvt_ctl_port_chk #(
    .ADDR_W  (P_ADDR_W),
    .CTRL_W  (P_N_CTRL*P_DATA_W),
    .N_CH    (P_N_CH),
    .PK_W    (P_PK_W),
    .N_CTRL  (P_N_CTRL),
    .FRAME_W (FW),
    .CNT_W   (CNTW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done_p),
    .rd     (c_rd),
    .addr   (c_addr),
    .ctrl   (ctrl_o),
    .pk     (pk_all),
    .clr    (pk_clr),
    .cnt    (bit_cnt),
    .cs_lvl (pin_s[1]),
    .sdo    (sdo_o)
);

// File: tb/cvt_ctl_port_tb_top.sv
module cvt_ctl_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        smp_vld = 1'b0;
    logic [47:0] smp = '0;
    logic [29:0] ctrl;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model
    logic [9:0]  m_ctrl [3];
    int          m_pk [2];
    bit          m_pend;
    logic [15:0] m_rsp;

    always #10 clk = ~clk;

    cvt_ctl_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .sdi_i     (sdi),
        .sdo_o     (sdo),
        .smp_vld_i (smp_vld),
        .smp_i     (smp),
        .ctrl_o    (ctrl)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_ctrl(input string req);
        for (int k = 0; k < 3; k++) check(req, {6'b0, ctrl[k*10 +: 10]}, {6'b0, m_ctrl[k]});
    endtask

    function automatic int mag6(input logic [23:0] s);
        int t;
        t = $signed(s[23:18]);
        return (t < 0) ? -t : t;
    endfunction

    task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nb; i++) begin
            sclk = 1'b0;
            sdi  = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(8);
            if (i < 16) got[15-i] = sdo;
            sclk = 1'b1;
            wait_clk(8);
        end
        sclk = 1'b0;
        wait_clk(8);
        cs_n = 1'b1;
        sdi  = 1'b0;
        wait_clk(10);
    endtask

    // one frame: checks the reply it carries and updates the model
    task automatic frame(input logic [15:0] w, input int nb, input string req);
        logic [15:0] got;
        logic [15:0] exp;
        int          a;
        exp = m_pend ? m_rsp : 16'h0;
        m_pend = 1'b0;
        xfer(w, nb, got);
        check(req, got, exp);
        if (nb == 16) begin
            a = int'(w[15:12]);
            if (w[11]) begin
                m_pend = 1'b1;
                m_rsp  = {w[15:12], 2'b00, 10'h0};
                if (a < 3) m_rsp[9:0] = m_ctrl[a];
                else if (a < 5) begin
                    m_rsp[9:0] = 10'(m_pk[a-3]);
                    m_pk[a-3] = 0;
                end
            end else if (a < 3) begin
                m_ctrl[a] = w[9:0];
            end
        end
    endtask

    task automatic put_smp(input logic [23:0] l, input logic [23:0] r);
        smp     = {r, l};
        smp_vld = 1'b1;
        wait_clk(1);
        smp_vld = 1'b0;
        wait_clk(2);
        if (m_ctrl[2][0]) begin
            if (mag6(l) > m_pk[0]) m_pk[0] = mag6(l);
            if (mag6(r) > m_pk[1]) m_pk[1] = mag6(r);
        end
    endtask

    function automatic logic [15:0] wr(input int a, input logic [9:0] d);
        return {4'(a), 2'b00, d};
    endfunction

    function automatic logic [15:0] rd(input int a);
        return {4'(a), 1'b1, 11'h0};
    endfunction

    task automatic t_reset;
        check("R10 ctrl", {6'b0, ctrl[9:0]}, 16'h0);
        check("R10 ctrl", {6'b0, ctrl[29:20]}, 16'h0);
        check("R10 sdo", {15'b0, sdo}, 16'h0);
        frame(rd(3), 16, "R10 no pending");
        frame(rd(4), 16, "R10 left peak zero");
        frame(wr(0, 10'h0), 16, "R10 right peak zero");
    endtask

    task automatic t_write;
        frame(wr(0, 10'h2A5), 16, "R4 idle reply");
        frame(wr(1, 10'h15A), 16, "R4 idle reply");
        frame(wr(2, 10'h001), 16, "R4 idle reply");
        check_ctrl("R1 R2 write");
    endtask

    task automatic t_bad_len;
        frame(wr(0, 10'h3FF), 15, "R3 short");
        check_ctrl("R3 15 clocks");
        frame(wr(1, 10'h3FF), 17, "R3 long");
        check_ctrl("R3 17 clocks");
    endtask

    task automatic t_ro_write;
        frame(wr(3, 10'h3FF), 16, "R5 reply");
        frame(wr(4, 10'h3FF), 16, "R5 reply");
        frame(wr(7, 10'h3FF), 16, "R5 reply");
        frame(wr(15, 10'h3FF), 16, "R5 reply");
        check_ctrl("R5 ro write");
        frame(rd(3), 16, "R5 reply");
        frame(rd(4), 16, "R5 left peak untouched");
        frame(wr(0, 10'h2A5), 16, "R5 right peak untouched");
    endtask

    task automatic t_readback;
        frame(rd(1), 16, "R4 before read");
        frame(rd(0), 16, "R4 reply reg1");
        frame(wr(1, 10'h0F0), 16, "R4 reply reg0");
        frame(rd(2), 16, "R4 zero after write");
        frame(rd(1), 16, "R4 reply reg2");
        frame(wr(0, 10'h133), 16, "R4 reply reg1 new");
        check_ctrl("R4 state");
    endtask

    task automatic t_unmapped;
        frame(rd(9), 16, "R6 before");
        frame(rd(15), 16, "R6 addr9 zero");
        frame(rd(5), 16, "R6 addr15 zero");
        frame(wr(0, 10'h133), 16, "R6 addr5 zero");
    endtask

    task automatic t_peak;
        put_smp(24'h100000, 24'h7FFFFF);
        put_smp(24'hF00000, 24'h800000);
        put_smp(24'h9A0000, 24'h040000);
        frame(rd(3), 16, "R7 before");
        frame(rd(4), 16, "R7 left peak");
        frame(rd(3), 16, "R7 right peak");
        frame(rd(4), 16, "R8 left cleared");
        frame(wr(0, 10'h133), 16, "R8 right cleared");
        put_smp(24'hFC0000, 24'h0C0000);
        frame(rd(3), 16, "R8 restart");
        frame(rd(4), 16, "R8 left restart");
        frame(wr(0, 10'h133), 16, "R8 right restart");
    endtask

    task automatic t_peak_off;
        frame(wr(2, 10'h000), 16, "R9 reply");
        put_smp(24'h800000, 24'h7FFFFF);
        frame(rd(3), 16, "R9 before");
        frame(rd(4), 16, "R9 left held");
        frame(wr(2, 10'h001), 16, "R9 right held");
        check_ctrl("R9 state");
    endtask

    task automatic t_cs_idle;
        logic [15:0] w;
        w = wr(0, 10'h3FF);
        frame(rd(0), 16, "R11 before");
        for (int i = 0; i < 16; i++) begin
            sdi  = w[15-i];
            sclk = 1'b0;
            wait_clk(8);
            sclk = 1'b1;
            wait_clk(8);
        end
        sclk = 1'b0;
        sdi  = 1'b0;
        wait_clk(10);
        check_ctrl("R11 idle clocks");
        frame(wr(1, 10'h0F0), 16, "R11 pending kept");
    endtask

    initial begin
        for (int k = 0; k < 3; k++) m_ctrl[k] = '0;
        m_pk[0] = 0;
        m_pk[1] = 0;
        m_pend  = 1'b0;
        m_rsp   = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write();
        t_bad_len();
        t_ro_write();
        t_readback();
        t_unmapped();
        t_peak();
        t_peak_off();
        t_cs_idle();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule